// File: doc/BRIEF.md
# Framed Serial DAC Control Receiver

This block terminates a three-wire serial write port for a voltage-output converter. A host lowers an active-low frame select, then shifts a 16-bit word in on the falling edges of a serial clock, most significant bit first. The two leading bits of the word carry an operating mode. The remaining fourteen bits carry a straight-binary converter code. The block keeps the code and mode in registers and drives the converter code, an amplifier enable and two output-termination enables from them.

The serial pins are oversampled in a faster system-clock domain. Each pin passes through a two-stage synchronizer, and edges are found from the synchronized levels. The system clock must run at least four times the serial clock rate. A frame takes effect only on its sixteenth falling serial-clock edge. If the frame select returns high before that edge, the frame is thrown away and no register changes. A one-cycle strobe reports each committed frame, and another reports each rejected one.

Top module: `dacrx_top`

## Requirements
- R1: While rst_ni is low and after its release, code_o is 0, amp_en_o is 1, pd_strong_o and pd_weak_o are 0, and upd_o and abort_o are 0.
- R2: A frame is the first 16 bits sampled on falling sclk_i edges after a falling cs_ni, most significant bit first. Bits 13:0 of the word are the converter code.
- R3: Word bits 15:14 select the mode. 00 drives amp_en_o=1. 01 drives pd_strong_o=1. 10 drives pd_weak_o=1. 11 drives all three low, which leaves the output high-impedance. At most one of the three outputs is high at any time.
- R4: The code and mode registers change only on the sixteenth falling sclk_i edge of a frame. upd_o pulses for one cycle in the same cycle as that change, which is three system-clock edges after the pin edge.
- R5: A rising cs_ni while a frame is open, before its sixteenth edge, pulses abort_o for one cycle and leaves the code and mode unchanged. upd_o and abort_o are never high together.
- R6: A committed frame whose mode field is not 00 updates the mode only and leaves code_o unchanged.
- R7: Falling sclk_i edges after the sixteenth, while cs_ni stays low, are ignored. cs_ni may stay low between bytes of one frame.
- R8: cs_ni rising after a frame has already committed does not pulse abort_o.
- R9: sclk_i activity while cs_ni is high changes no output.
- R10: A falling cs_ni clears the bit count, so a full frame that follows an aborted one commits normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock rate |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cs_ni | input | 1 | Active-low frame select pin |
| sclk_i | input | 1 | Serial clock pin; data is taken on its falling edges |
| sdin_i | input | 1 | Serial data pin |
| code_o | output | 14 | Stored converter code |
| amp_en_o | output | 1 | Output amplifier enable (mode 00) |
| pd_strong_o | output | 1 | Low-value pull-down load enable (mode 01) |
| pd_weak_o | output | 1 | High-value pull-down load enable (mode 10) |
| upd_o | output | 1 | One-cycle strobe when a frame commits |
| abort_o | output | 1 | One-cycle strobe when an open frame is rejected |

## Verification
A pin edge shows up as a change at the outputs on the third rising system-clock edge after the pins change. The strobes last exactly that one cycle, and the code and termination outputs then hold. The reference model in the bench keeps the pin levels it has seen at each rising edge. It evaluates the edge two and three samples back, which gives the same latency, and its outputs are compared with the design at every falling clock edge. The directed checks on code and mode values are made only after the pins have been still for at least four cycles, so each directed check samples a settled result.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN       = 2'b00,
    MODE_PD_STRONG = 2'b01,
    MODE_PD_WEAK   = 2'b10,
    MODE_PD_HIZ    = 2'b11
  } mode_e;
endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= RST_VAL;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dacrx_edge.sv
module dacrx_edge #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
  assign rise_o = ~prev_q & lvl_i;
endmodule

// File: rtl/dacrx_frame.sv
module dacrx_frame #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_lvl_i,
  input  logic               cs_fall_i,
  input  logic               cs_rise_i,
  input  logic               sclk_fall_i,
  input  logic               sdin_i,
  output logic               commit_o,
  output logic               abort_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic               act_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-2:0] sh_q;
  logic               bit_ev;

  always_comb begin
    word_o   = {sh_q, sdin_i};
    bit_ev   = act_q && !cs_lvl_i && sclk_fall_i && !cs_fall_i && !cs_rise_i;
    commit_o = bit_ev && (cnt_q == LAST_BIT);
    abort_o  = act_q && cs_rise_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cs_fall_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cs_rise_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (bit_ev) begin
      if (commit_o) begin
        // frame closed; wait for a fresh select
        act_q <= 1'b0;
        cnt_q <= '0;
        sh_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= word_o[FRAME_W-2:0];
      end
    end
  end
endmodule

// File: rtl/dacrx_regs.sv
module dacrx_regs
  import dacrx_pkg::*;
#(
  parameter int CODE_W = 14
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     commit_i,
  input  logic                     abort_i,
  input  logic [CODE_W+MODE_W-1:0] word_i,
  output logic [CODE_W-1:0]        code_o,
  output logic                     amp_en_o,
  output logic                     pd_strong_o,
  output logic                     pd_weak_o,
  output logic                     upd_o,
  output logic                     abort_o
);
  mode_e             mode_q, mode_new;
  logic [CODE_W-1:0] code_q;
  logic              upd_q, abt_q;

  assign mode_new = mode_e'(word_i[CODE_W +: MODE_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      code_q <= '0;
      upd_q  <= 1'b0;
      abt_q  <= 1'b0;
    end else begin
      upd_q <= commit_i;
      abt_q <= abort_i;
      if (commit_i) begin
        mode_q <= mode_new;
        // power-down frames keep the stored code
        if (mode_new == MODE_RUN) code_q <= word_i[CODE_W-1:0];
      end
    end
  end

  always_comb begin
    amp_en_o    = 1'b0;
    pd_strong_o = 1'b0;
    pd_weak_o   = 1'b0;
    unique case (mode_q)
      MODE_RUN:       amp_en_o    = 1'b1;
      MODE_PD_STRONG: pd_strong_o = 1'b1;
      MODE_PD_WEAK:   pd_weak_o   = 1'b1;
      MODE_PD_HIZ:    ;
      default:        ;
    endcase
  end

  assign code_o  = code_q;
  assign upd_o   = upd_q;
  assign abort_o = abt_q;
endmodule

// File: rtl/dacrx_top.sv
module dacrx_top
  import dacrx_pkg::*;
#(
  parameter int CODE_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic [CODE_W-1:0] code_o,
  output logic              amp_en_o,
  output logic              pd_strong_o,
  output logic              pd_weak_o,
  output logic              upd_o,
  output logic              abort_o
);
  localparam int FRAME_W = CODE_W + MODE_W;
  localparam logic [2:0] PIN_RST = 3'b100; // {cs, sclk, sdin}

  logic [2:0] pin_s, pin_fall, pin_rise;
  logic       commit, abort_ev;
  logic [FRAME_W-1:0] word;

  dacrx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdin_i}),
    .q_o   (pin_s)
  );

  dacrx_edge #(.W(3), .RST_VAL(PIN_RST)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_s),
    .fall_o(pin_fall),
    .rise_o(pin_rise)
  );

  dacrx_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_lvl_i   (pin_s[2]),
    .cs_fall_i  (pin_fall[2]),
    .cs_rise_i  (pin_rise[2]),
    .sclk_fall_i(pin_fall[1]),
    .sdin_i     (pin_s[0]),
    .commit_o   (commit),
    .abort_o    (abort_ev),
    .word_o     (word)
  );

  dacrx_regs #(.CODE_W(CODE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .abort_i    (abort_ev),
    .word_i     (word),
    .code_o     (code_o),
    .amp_en_o   (amp_en_o),
    .pd_strong_o(pd_strong_o),
    .pd_weak_o  (pd_weak_o),
    .upd_o      (upd_o),
    .abort_o    (abort_o)
  );

  logic unused_rise;
  assign unused_rise = ^{pin_rise[1:0], pin_fall[0]};
endmodule

// File: rtl/dacrx_chk.sv
module dacrx_chk #(
  parameter int CODE_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_o,
  input logic              amp_en_o,
  input logic              pd_strong_o,
  input logic              pd_weak_o,
  input logic              upd_o,
  input logic              abort_o
);
  assert_term_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({amp_en_o, pd_strong_o, pd_weak_o}));

  assert_code_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> upd_o);

  assert_mode_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({amp_en_o, pd_strong_o, pd_weak_o}) |-> upd_o);

  assert_upd_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  assert_abort_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_o && abort_o));

  assert_pd_code_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && !amp_en_o) |-> $stable(code_o));
endmodule

bind dacrx_top dacrx_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .code_o     (code_o),
  .amp_en_o   (amp_en_o),
  .pd_strong_o(pd_strong_o),
  .pd_weak_o  (pd_weak_o),
  .upd_o      (upd_o),
  .abort_o    (abort_o)
);

// File: tb/tb_dacrx_top.sv
`timescale 1ns/1ps
module tb_dacrx_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic [13:0] code;
  logic amp, pds, pdw, upd, abt;

  int n_tests = 0, n_fail = 0;
  bit done = 0, abt_seen = 0, upd_seen = 0;

  always #(CLK_P/2) clk = ~clk;

  dacrx_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .sclk_i(sclk), .sdin_i(sdin),
    .code_o(code), .amp_en_o(amp), .pd_strong_o(pds), .pd_weak_o(pdw),
    .upd_o(upd), .abort_o(abt)
  );

  // reference model: pin history sampled at each rising edge
  int h_cs[3], h_sc[3], h_sd[3];
  int m_act, m_cnt, m_sh, m_code, m_mode, m_upd, m_abt;

  task automatic hist_reset();
    for (int i = 0; i < 3; i++) begin h_cs[i] = 1; h_sc[i] = 0; h_sd[i] = 0; end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_reset();
      m_act = 0; m_cnt = 0; m_sh = 0; m_code = 0; m_mode = 0; m_upd = 0; m_abt = 0;
    end else begin
      m_upd = 0; m_abt = 0;
      if (h_cs[1] == 0 && h_cs[2] == 1) begin
        m_act = 1; m_cnt = 0; m_sh = 0;
      end else if (h_cs[1] == 1 && h_cs[2] == 0) begin
        if (m_act != 0) m_abt = 1;
        m_act = 0; m_cnt = 0; m_sh = 0;
      end else if (m_act != 0 && h_sc[1] == 0 && h_sc[2] == 1) begin
        m_sh = ((m_sh << 1) | h_sd[1]) & 16'hFFFF;
        m_cnt++;
        if (m_cnt == 16) begin
          m_mode = m_sh >> 14;
          if (m_mode == 0) m_code = m_sh & 16'h3FFF;
          m_upd = 1; m_act = 0; m_cnt = 0; m_sh = 0;
        end
      end
      h_cs[2] = h_cs[1]; h_cs[1] = h_cs[0]; h_cs[0] = int'(cs_n);
      h_sc[2] = h_sc[1]; h_sc[1] = h_sc[0]; h_sc[0] = int'(sclk);
      h_sd[2] = h_sd[1]; h_sd[1] = h_sd[0]; h_sd[0] = int'(sdin);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R2 code vs model", int'(code), m_code);
      chk("R3 terminations vs model", int'({amp, pds, pdw}),
          int'({m_mode == 0, m_mode == 1, m_mode == 2}));
      chk("R4 update strobe vs model", int'(upd), m_upd);
      chk("R5 abort strobe vs model", int'(abt), m_abt);
      if (abt) abt_seen = 1;
      if (upd) upd_seen = 1;
    end
  end

  task automatic open_frame();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n, input bit rel);
    for (int i = 0; i < n; i++) begin
      sdin = w[15-i];
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    if (rel) begin
      repeat (2) @(negedge clk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic send(input logic [15:0] w);
    abt_seen = 0; upd_seen = 0;
    open_frame();
    shift_bits(w, 16, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 code in reset", int'(code), 0);
    chk("R1 amp in reset", int'({amp, pds, pdw, upd, abt}), 5'b10000);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 code after reset", int'(code), 0);
    chk("R1 amp after reset", int'({amp, pds, pdw}), 3'b100);

    send(16'h1234);
    chk("R2 code 0x1234", int'(code), 16'h1234);
    chk("R3 mode 00 amp on", int'({amp, pds, pdw}), 3'b100);
    chk("R4 update seen", int'(upd_seen), 1);

    send({2'b01, 14'h0555});
    chk("R6 code kept mode 01", int'(code), 16'h1234);
    chk("R3 mode 01 strong", int'({amp, pds, pdw}), 3'b010);

    send({2'b10, 14'h2AAA});
    chk("R6 code kept mode 10", int'(code), 16'h1234);
    chk("R3 mode 10 weak", int'({amp, pds, pdw}), 3'b001);

    send({2'b11, 14'h3FFF});
    chk("R3 mode 11 hiz", int'({amp, pds, pdw}), 3'b000);
    chk("R6 code kept mode 11", int'(code), 16'h1234);

    send({2'b00, 14'h3FFF});
    chk("R6 normal restores code", int'(code), 16'h3FFF);
    chk("R3 mode 00 again", int'({amp, pds, pdw}), 3'b100);

    abt_seen = 0; upd_seen = 0;
    open_frame();
    shift_bits({2'b01, 14'h0011}, 8, 1);
    chk("R5 abort strobe", int'(abt_seen), 1);
    chk("R5 no commit", int'(upd_seen), 0);
    chk("R5 code kept", int'(code), 16'h3FFF);
    chk("R5 mode kept", int'({amp, pds, pdw}), 3'b100);

    abt_seen = 0; upd_seen = 0;
    open_frame();
    shift_bits(16'h2ABC, 8, 0);
    repeat (10) @(negedge clk);
    chk("R7 no commit mid frame", int'(upd_seen), 0);
    shift_bits(16'hBC00, 8, 1);
    chk("R7 two-byte frame code", int'(code), 16'h2ABC);

    abt_seen = 0; upd_seen = 0;
    open_frame();
    shift_bits(16'h0123, 16, 0);
    chk("R4 commit on 16th edge", int'(code), 16'h0123);
    upd_seen = 0;
    shift_bits(16'hFFFF, 4, 1);
    chk("R7 extra edges ignored", int'(code), 16'h0123);
    chk("R7 no second update", int'(upd_seen), 0);
    chk("R8 no abort after commit", int'(abt_seen), 0);

    abt_seen = 0; upd_seen = 0;
    shift_bits(16'hFFFF, 16, 0);
    repeat (6) @(negedge clk);
    chk("R9 sclk with select high", int'(code), 16'h0123);
    chk("R9 no strobe", int'(upd_seen | abt_seen), 0);

    abt_seen = 0;
    open_frame();
    shift_bits(16'hC000, 5, 1);
    chk("R10 abort seen", int'(abt_seen), 1);
    send(16'h0F0F);
    chk("R10 frame after abort", int'(code), 16'h0F0F);
    chk("R10 mode normal", int'({amp, pds, pdw}), 3'b100);

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule